// File: doc/BRIEF.md
# Exception Control Register File

This block keeps the machine state that a processor's exception logic needs: a status word, a cause word, a saved exception program counter and a captured faulting address. The status word holds an interrupt mask with one bit per level and a three-deep stack of (kernel/user, interrupt enable) pairs. The cause word holds latched interrupt flags and the code of the most recent exception. The controller pulses an entry strobe when it takes an exception and a return strobe when the handler finishes. The block updates its registers on those pulses and asserts one interrupt request line back to the controller.

Software reads and writes the four registers through a small select-and-write port. Reads are combinational. Writes take effect at the next clock edge. Five hardware request lines are sampled every cycle and are latched as pending even while interrupts are disabled or masked. Three further pending levels are owned by software.

Top module: `exc_ctrl_regs`

## Requirements
- R1: After synchronous reset, all four registers read 0 and `irq_out` is 0.
- R2: On an `exc_enter` cycle, status bits 5:0 become {old bits 3:0, 2'b00}, so the new current pair (bit 1 kernel/user, bit 0 enable) is 0. Mask bits 15:8 keep their value.
- R3: On an `exc_return` cycle without `exc_enter`, status bits 3:0 take old bits 5:2 and bits 5:4 keep their value. `exc_enter` wins over a same-cycle `exc_return`.
- R4: A high `hw_irq[i]` sets cause bit 11+i at the next edge, whatever the enable and mask values. The bit stays set until a cause write carries 0 in that position while the line is low. If the line is high in the same cycle as such a write, the set wins.
- R5: Cause bits 10:8 are software pending levels that a cause write loads directly.
- R6: On `exc_enter`, cause bits 5:2 load `exc_code` (0 external interrupt, 4 load/fetch address error, 5 store address error, 6 fetch bus error, 7 data bus error, 8 syscall, 9 breakpoint, 10 reserved instruction, 12 overflow). Software writes to these bits are ignored. Cause bits 31:16, 7:6 and 1:0 read 0.
- R7: On `exc_enter`, the exception PC register loads `exc_pc` unchanged (the faulting instruction's address). Otherwise a write to select 2 loads it.
- R8: The bad-address register loads `exc_badaddr` only on an `exc_enter` cycle with `exc_badaddr_vld` high. Software writes to it are ignored.
- R9: `irq_out` is 1 exactly when status bit 0 is 1 and some cause bit 8+j and status bit 8+j are both 1.
- R10: A software write in the same cycle as `exc_enter` has no effect on any register.
- R11: A status write, with no entry or return in that cycle, loads bits 15:8 and 5:0. All other status bits read 0.
- R12: `reg_sel` encoding: 0 status, 1 cause, 2 exception PC, 3 bad address. `reg_rdata` shows the selected register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_enter | input | 1 | Exception entry strobe |
| exc_code | input | 4 | Exception code recorded on entry |
| exc_pc | input | 32 | Address of the faulting instruction |
| exc_badaddr_vld | input | 1 | Entry is due to a memory reference fault |
| exc_badaddr | input | 32 | Faulting memory address |
| exc_return | input | 1 | Return-from-exception strobe |
| hw_irq | input | 5 | Hardware interrupt request lines |
| reg_sel | input | 2 | Register select for software access |
| reg_we | input | 1 | Software write enable |
| reg_wdata | input | 32 | Software write data |
| reg_rdata | output | 32 | Selected register value |
| irq_out | output | 1 | Interrupt request to the controller |

## Verification
Several functions can land on the same edge. An entry strobe can meet a software write to any register, an entry can meet a return, and a software clear of a pending flag can meet an active request line on that bit. The random phase raises entry, return, request lines and writes independently, so these overlaps occur often. Directed cycles force each overlap at least once. After every edge, all four registers and the request line are compared with a bench model that applies the priorities in R3, R4 and R10.

// File: rtl/exc_regs_pkg.sv
`timescale 1ns/100ps
package exc_regs_pkg;
    localparam int XLEN     = 32;
    localparam int N_HW     = 5;
    localparam int N_SW     = 3;
    localparam int N_LVL    = N_HW + N_SW;
    localparam int CODE_W   = 4;
    localparam int STACK_W  = 6;
    localparam int SEL_W    = 2;
    localparam int MASK_LSB = 8;
    localparam int PEND_LSB = 8;
    localparam int CODE_LSB = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS  = 2'd0,
        SEL_CAUSE   = 2'd1,
        SEL_EPC     = 2'd2,
        SEL_BADADDR = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [N_LVL-1:0]   mask;
        logic [STACK_W-1:0] stack;
    } status_t;

    typedef struct packed {
        logic [N_LVL-1:0]  pend;
        logic [CODE_W-1:0] code;
    } cause_t;

    // push a fresh (kernel, disabled) pair onto the mode stack
    function automatic logic [STACK_W-1:0] stack_push(input logic [STACK_W-1:0] s);
        return {s[STACK_W-3:0], 2'b00};
    endfunction

    // pop one pair, the oldest pair is duplicated
    function automatic logic [STACK_W-1:0] stack_pop(input logic [STACK_W-1:0] s);
        return {s[STACK_W-1:STACK_W-2], s[STACK_W-1:2]};
    endfunction

    function automatic logic [XLEN-1:0] status_word(input status_t s);
        logic [XLEN-1:0] w;
        w = '0;
        w[MASK_LSB +: N_LVL] = s.mask;
        w[0 +: STACK_W]      = s.stack;
        return w;
    endfunction

    function automatic logic [XLEN-1:0] cause_word(input cause_t c);
        logic [XLEN-1:0] w;
        w = '0;
        w[PEND_LSB +: N_LVL]  = c.pend;
        w[CODE_LSB +: CODE_W] = c.code;
        return w;
    endfunction
endpackage

// File: rtl/exc_status_unit.sv
`timescale 1ns/100ps
module exc_status_unit
    import exc_regs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    enter,
    input  logic    ret,
    input  logic    wr,
    input  status_t wr_val,
    output status_t st_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (enter) begin
            st_q.stack <= stack_push(st_q.stack);
        end else if (ret) begin
            st_q.stack <= stack_pop(st_q.stack);
        end else if (wr) begin
            st_q <= wr_val;
        end
    end
endmodule

// File: rtl/exc_cause_unit.sv
`timescale 1ns/100ps
module exc_cause_unit
    import exc_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enter,
    input  logic [CODE_W-1:0] code_in,
    input  logic [N_HW-1:0]   hw_irq,
    input  logic              wr,
    input  logic [N_LVL-1:0]  wr_pend,
    output cause_t            ca_q
);
    logic [N_HW-1:0]   pend_hw_q;
    logic [N_SW-1:0]   pend_sw_q;
    logic [CODE_W-1:0] code_q;

    for (genvar i = 0; i < N_HW; i++) begin : g_hw
        always_ff @(posedge clk) begin
            if (rst)
                pend_hw_q[i] <= 1'b0;
            else if (hw_irq[i])
                pend_hw_q[i] <= 1'b1;
            else if (wr && !wr_pend[N_SW+i])
                pend_hw_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend_sw_q <= '0;
        else if (wr)
            pend_sw_q <= wr_pend[N_SW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= '0;
        else if (enter)
            code_q <= code_in;
    end

    assign ca_q.pend = {pend_hw_q, pend_sw_q};
    assign ca_q.code = code_q;
endmodule

// File: rtl/exc_addr_unit.sv
`timescale 1ns/100ps
module exc_addr_unit
    import exc_regs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            enter,
    input  logic [XLEN-1:0] pc_in,
    input  logic            bad_vld,
    input  logic [XLEN-1:0] bad_in,
    input  logic            wr_epc,
    input  logic [XLEN-1:0] wr_val,
    output logic [XLEN-1:0] epc_q,
    output logic [XLEN-1:0] bad_q
);
    always_ff @(posedge clk) begin
        if (rst)
            epc_q <= '0;
        else if (enter)
            epc_q <= pc_in;
        else if (wr_epc)
            epc_q <= wr_val;
    end

    always_ff @(posedge clk) begin
        if (rst)
            bad_q <= '0;
        else if (enter && bad_vld)
            bad_q <= bad_in;
    end
endmodule

// File: rtl/exc_ctrl_regs.sv
`timescale 1ns/100ps
module exc_ctrl_regs
    import exc_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_enter,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic              exc_badaddr_vld,
    input  logic [XLEN-1:0]   exc_badaddr,
    input  logic              exc_return,
    input  logic [N_HW-1:0]   hw_irq,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_we,
    input  logic [XLEN-1:0]   reg_wdata,
    output logic [XLEN-1:0]   reg_rdata,
    output logic              irq_out
);
    reg_sel_e        sel;
    logic            sw_ok;
    logic            wr_status, wr_cause, wr_epc;
    status_t         st_wr_val;
    status_t         st_q;
    cause_t          ca_q;
    logic [XLEN-1:0] epc_q, bad_q;

    assign sel       = reg_sel_e'(reg_sel);
    assign sw_ok     = reg_we && !exc_enter;
    assign wr_status = sw_ok && (sel == SEL_STATUS);
    assign wr_cause  = sw_ok && (sel == SEL_CAUSE);
    assign wr_epc    = sw_ok && (sel == SEL_EPC);

    assign st_wr_val.mask  = reg_wdata[MASK_LSB +: N_LVL];
    assign st_wr_val.stack = reg_wdata[0 +: STACK_W];

    exc_status_unit u_status (
        .clk    (clk),
        .rst    (rst),
        .enter  (exc_enter),
        .ret    (exc_return),
        .wr     (wr_status),
        .wr_val (st_wr_val),
        .st_q   (st_q)
    );

    exc_cause_unit u_cause (
        .clk     (clk),
        .rst     (rst),
        .enter   (exc_enter),
        .code_in (exc_code),
        .hw_irq  (hw_irq),
        .wr      (wr_cause),
        .wr_pend (reg_wdata[PEND_LSB +: N_LVL]),
        .ca_q    (ca_q)
    );

    exc_addr_unit u_addr (
        .clk     (clk),
        .rst     (rst),
        .enter   (exc_enter),
        .pc_in   (exc_pc),
        .bad_vld (exc_badaddr_vld),
        .bad_in  (exc_badaddr),
        .wr_epc  (wr_epc),
        .wr_val  (reg_wdata),
        .epc_q   (epc_q),
        .bad_q   (bad_q)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS:  reg_rdata = status_word(st_q);
            SEL_CAUSE:   reg_rdata = cause_word(ca_q);
            SEL_EPC:     reg_rdata = epc_q;
            SEL_BADADDR: reg_rdata = bad_q;
            default:     reg_rdata = '0;
        endcase
    end

    assign irq_out = st_q.stack[0] & (|(ca_q.pend & st_q.mask));
endmodule

// File: rtl/exc_ctrl_regs_chk.sv
`timescale 1ns/100ps
module exc_ctrl_regs_chk
    import exc_regs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              exc_enter,
    input logic              exc_return,
    input logic [CODE_W-1:0] exc_code,
    input logic [XLEN-1:0]   exc_pc,
    input logic [N_HW-1:0]   hw_irq,
    input logic              irq_out,
    input status_t           st_q,
    input cause_t            ca_q,
    input logic [XLEN-1:0]   epc_q
);
    assert_entry_push_R2: assert property (@(posedge clk) disable iff (rst)
        exc_enter |=> (st_q.stack[1:0] == 2'b00)
                   && (st_q.stack[5:2] == $past(st_q.stack[3:0]))
                   && (st_q.mask == $past(st_q.mask)));

    assert_return_pop_R3: assert property (@(posedge clk) disable iff (rst)
        (exc_return && !exc_enter) |=> (st_q.stack[5:4] == $past(st_q.stack[5:4]))
                                    && (st_q.stack[3:0] == $past(st_q.stack[5:2])));

    assert_hw_latch_R4: assert property (@(posedge clk) disable iff (rst)
        (hw_irq != '0) |=> ((ca_q.pend[N_LVL-1:N_SW] & $past(hw_irq)) == $past(hw_irq)));

    assert_code_load_R6: assert property (@(posedge clk) disable iff (rst)
        exc_enter |=> ca_q.code == $past(exc_code));

    assert_epc_load_R7: assert property (@(posedge clk) disable iff (rst)
        exc_enter |=> epc_q == $past(exc_pc));

    assert_irq_needs_pend_R9: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (ca_q.pend != '0) && st_q.stack[0]);
endmodule

bind exc_ctrl_regs exc_ctrl_regs_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .exc_enter  (exc_enter),
    .exc_return (exc_return),
    .exc_code   (exc_code),
    .exc_pc     (exc_pc),
    .hw_irq     (hw_irq),
    .irq_out    (irq_out),
    .st_q       (st_q),
    .ca_q       (ca_q),
    .epc_q      (epc_q)
);

// File: tb/tb_exc_ctrl_regs.sv
`timescale 1ns/100ps
module tb_exc_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst;
    logic        exc_enter = 0, exc_badaddr_vld = 0, exc_return = 0, reg_we = 0;
    logic [3:0]  exc_code = 0;
    logic [31:0] exc_pc = 0, exc_badaddr = 0, reg_wdata = 0;
    logic [4:0]  hw_irq = 0;
    logic [1:0]  reg_sel = 0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model
    logic [7:0]  m_mask = 0, m_pend = 0;
    logic [5:0]  m_stack = 0;
    logic [3:0]  m_code = 0;
    logic [31:0] m_epc = 0, m_bad = 0;

    exc_ctrl_regs dut (
        .clk(clk), .rst(rst), .exc_enter(exc_enter), .exc_code(exc_code),
        .exc_pc(exc_pc), .exc_badaddr_vld(exc_badaddr_vld), .exc_badaddr(exc_badaddr),
        .exc_return(exc_return), .hw_irq(hw_irq), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] exp_reg(input int s);
        case (s)
            0: return {16'h0, m_mask, 2'b00, m_stack};
            1: return {16'h0, m_pend, 2'b00, m_code, 2'b00};
            2: return m_epc;
            default: return m_bad;
        endcase
    endfunction

    function automatic logic exp_irq();
        return m_stack[0] & (|(m_pend & m_mask));
    endfunction

    // next-state model from the requirements, applied before the edge
    task automatic model_update();
        logic sw;
        sw = reg_we && !exc_enter;
        for (int i = 0; i < 5; i++) begin
            if (hw_irq[i]) m_pend[3+i] = 1'b1;
            else if (sw && reg_sel == 2'd1 && !reg_wdata[11+i]) m_pend[3+i] = 1'b0;
        end
        if (sw && reg_sel == 2'd1) m_pend[2:0] = reg_wdata[10:8];
        if (exc_enter) begin
            m_stack = {m_stack[3:0], 2'b00};
            m_code  = exc_code;
            m_epc   = exc_pc;
            if (exc_badaddr_vld) m_bad = exc_badaddr;
        end else if (exc_return) begin
            m_stack = {m_stack[5:4], m_stack[5:2]};
        end else if (sw && reg_sel == 2'd0) begin
            m_mask  = reg_wdata[15:8];
            m_stack = reg_wdata[5:0];
        end
        if (sw && reg_sel == 2'd2) m_epc = reg_wdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        string t;
        for (int s = 0; s < 4; s++) begin
            reg_sel = s[1:0];
            #0.5;
            if (tag != "") t = tag;
            else t = (s == 0) ? "R2" : (s == 1) ? "R4" : (s == 2) ? "R7" : "R8";
            chk(t, reg_rdata, exp_reg(s));
        end
        chk((tag != "") ? tag : "R9", {31'b0, irq_out}, {31'b0, exp_irq()});
    endtask

    task automatic run_cycle(input string tag);
        model_update();
        @(posedge clk);
        #1;
        exc_enter = 0; exc_return = 0; reg_we = 0;
        compare_all(tag);
        @(negedge clk);
    endtask

    task automatic sw_write(input logic [1:0] s, input logic [31:0] d);
        reg_we = 1; reg_sel = s; reg_wdata = d;
    endtask

    function automatic logic [3:0] pick_code();
        logic [3:0] codes [9] = '{4'd0, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd12};
        return codes[$urandom % 9];
    endfunction

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        compare_all("R1");

        // R11: status write, reserved bits read 0
        sw_write(2'd0, 32'hFFFF_FFFF);           run_cycle("R11");
        // R12: select 2 is the exception PC
        sw_write(2'd2, 32'hA5A5_0004);           run_cycle("R12");
        // R5: software pending levels, irq rises (R9)
        sw_write(2'd1, 32'h0000_0500);           run_cycle("R5");
        // R6: code bits ignored on a cause write
        sw_write(2'd1, 32'h0000_003C);           run_cycle("R6");
        // R10: entry with same-cycle status write of 0
        exc_enter = 1; exc_code = 4'd10; exc_pc = 32'h0000_1000;
        exc_badaddr_vld = 0; exc_badaddr = 32'hDEAD_BEEF;
        sw_write(2'd0, 32'h0);                   run_cycle("R10");
        // R10: entry with same-cycle EPC write
        exc_enter = 1; exc_code = 4'd12; exc_pc = 32'h0000_2000;
        sw_write(2'd2, 32'h1111_1111);           run_cycle("R10");
        // R8: bad address captured on faulting entry
        exc_enter = 1; exc_code = 4'd4; exc_badaddr_vld = 1; exc_badaddr = 32'hCAFE_0010;
        run_cycle("R8");
        exc_badaddr_vld = 0;
        sw_write(2'd3, 32'h0);                   run_cycle("R8");
        // R3: return, then entry and return together
        exc_return = 1;                          run_cycle("R3");
        exc_return = 1; exc_enter = 1;           run_cycle("R3");
        // R4: latch while disabled, clear contested by live line
        sw_write(2'd0, 32'h0000_0000);           run_cycle("R11");
        hw_irq = 5'b00100;                       run_cycle("R4");
        hw_irq = 5'b00000;                       run_cycle("R4");
        hw_irq = 5'b00100; sw_write(2'd1, 32'h0); run_cycle("R4");
        hw_irq = 5'b00000; sw_write(2'd1, 32'h0); run_cycle("R4");
        // R9: enabled but masked, then unmasked
        hw_irq = 5'b10000;                       run_cycle("R9");
        hw_irq = 5'b00000; sw_write(2'd0, 32'h0000_7F01); run_cycle("R9");
        sw_write(2'd0, 32'h0000_8001);           run_cycle("R9");

        // random phase
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom % 8;
            exc_enter       = (r == 0);
            exc_return      = (r == 1) || ((r == 2) && ($urandom % 2 == 0));
            if (r == 2) exc_enter = 1;
            exc_code        = pick_code();
            exc_pc          = $urandom;
            exc_badaddr     = $urandom;
            exc_badaddr_vld = $urandom % 2;
            hw_irq          = ($urandom % 4 == 0) ? 5'($urandom) : 5'b0;
            reg_we          = ($urandom % 3 == 0);
            reg_sel         = 2'($urandom);
            reg_wdata       = $urandom;
            run_cycle("");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule